// File: doc/BRIEF.md
# Glitch-Free Programmable Clock Output

This block derives an output clock from a 48 MHz reference clock. A 4-bit divide value N sets the output to 48/(N+1) MHz, so the range is 3 MHz to 48 MHz. When N is 0, the reference passes straight through. A new N is picked up only at the end of the output period in progress, while the output is low, so a change of frequency never cuts a pulse short.

The block also manages suspend. A one-cycle suspend request starts a delay timer of DELAY reference cycles, which stands in for the roughly 2 ms wait. When the timer expires, one of two things happens:
- If the slow-clock disable bit is clear, the output moves to a slow low-power clock input, about 115 kHz.
- If the slow-clock disable bit is set, the output goes quiet and stays low.

At the same moment the internal clock enable drops, unless the always-run bit is set. A wake event ends suspend: the clock enable comes back on the next edge and the divided clock returns at a safe boundary. Moving between the two clock sources uses a break-before-make handshake. It is a four-phase exchange with two-flop synchronisers in each direction.

Top module: `clkout_gen`

## Requirements
- R1: While reset is asserted and in the first cycle after it, clk_out is low and core_clk_en is high.
- R2: With N from 1 to 15, clk_out has a period of N+1 reference cycles and a high phase of floor((N+1)/2) reference cycles.
- R3: A new div_n value takes effect only at the end of an output period. Across any change of div_n, every high and every low pulse on clk_out lasts at least half a reference period.
- R4: With N = 0, clk_out follows the reference clock: one reference period, half of it high.
- R5: The gate for the divided clock and the gate for the slow clock are never both open.
- R6: The divided-clock gate opens or closes only while the divided output is low.
- R7: After a one-cycle suspend_req sampled at reference edge k, with clk_keep = 0, core_clk_en is still high after edge k+DELAY and is low after edge k+DELAY+1.
- R8: With slow_off = 0, once the suspend delay has expired, clk_out carries the slow clock: the same period and high time as clk_slow.
- R9: With slow_off = 1, once the suspend delay has expired, clk_out shows no rising edge until wake.
- R10: With clk_keep = 1, core_clk_en stays high through suspend, and it is high on the edge after any cycle in which clk_keep is high.
- R11: A wake pulse sampled at edge j drives core_clk_en high after edge j+1. The divided clock then returns on clk_out with the period set by R2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ref | input | 1 | 48 MHz reference clock |
| clk_slow | input | 1 | Slow low-power clock, used during suspend |
| rst | input | 1 | Synchronous active-high hard reset |
| div_n | input | 4 | Divide value N; output = ref/(N+1) |
| suspend_req | input | 1 | One-cycle pulse that starts the suspend delay |
| wake | input | 1 | One-cycle pulse that ends suspend |
| slow_off | input | 1 | 1: output quiet in suspend; 0: slow clock in suspend |
| clk_keep | input | 1 | 1: internal clock enable held high through suspend |
| clk_out | output | 1 | Programmable clock output |
| core_clk_en | output | 1 | Internal clock enable indication |

## Verification
The assertions assume the following about the inputs:
- clk_ref and clk_slow are free-running with a 50 % duty cycle.
- rst is held for several slow-clock periods, so that the slow-domain flops are cleared.
- suspend_req and wake are single-cycle pulses in the reference domain and never arrive together.

The stimulus drives every input on the falling reference edge and gives each pulse exactly one cycle. It holds reset for ten reference cycles, which covers more than two slow periods. It waits for the handshake to settle before any period is measured. Changes of div_n land at assorted points within the output period, so that the pulse-width monitor sees reloads in both the high phase and the low phase.

// File: rtl/clkout_pkg.sv
`timescale 1ns/1ps
package clkout_pkg;
  localparam int DIV_W = 4;

  // High-phase length in reference cycles for divide value n: floor((n+1)/2)
  function automatic logic [DIV_W:0] hi_len(input logic [DIV_W-1:0] n);
    logic [DIV_W:0] t;
    t = {1'b0, n} + 1'b1;
    return t >> 1;
  endfunction
endpackage

// File: rtl/clkout_div.sv
`timescale 1ns/1ps
module clkout_div
  import clkout_pkg::*;
#(
  parameter int W = DIV_W
) (
  input  logic         clk_ref,
  input  logic         rst,
  input  logic [W-1:0] div_n,
  output logic         fast_clk,
  output logic         div_hi,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] n_cur_o
);
  logic [W-1:0] cnt, n_cur, cnt_nx, n_nx;
  logic         div_q, pass_en;

  // Reload of the divide value happens only at the last cycle of a period
  always_comb begin
    if (cnt == n_cur) begin
      cnt_nx = '0;
      n_nx   = div_n;
    end else begin
      cnt_nx = cnt + 1'b1;
      n_nx   = n_cur;
    end
  end

  always_ff @(posedge clk_ref) begin
    if (rst) begin
      cnt   <= '0;
      n_cur <= '0;
      div_q <= 1'b0;
    end else begin
      cnt   <= cnt_nx;
      n_cur <= n_nx;
      div_q <= ({1'b0, cnt_nx} < hi_len(n_nx));
    end
  end

  // Pass-through select changes while the reference is low
  always_ff @(negedge clk_ref) begin
    if (rst) pass_en <= 1'b0;
    else     pass_en <= (n_cur == '0);
  end

  assign fast_clk = div_q | (clk_ref & pass_en);
  assign div_hi   = div_q;
  assign cnt_o    = cnt;
  assign n_cur_o  = n_cur;
endmodule

// File: rtl/clkout_susp.sv
`timescale 1ns/1ps
module clkout_susp #(
  parameter int DELAY = 96000
) (
  input  logic clk_ref,
  input  logic rst,
  input  logic suspend_req,
  input  logic wake,
  input  logic clk_keep,
  output logic susp_active,
  output logic core_clk_en
);
  localparam int CW = $clog2(DELAY) + 1;
  localparam logic [CW-1:0] LAST = CW'(DELAY - 1);

  logic [CW-1:0] t_cnt;
  logic          armed;

  always_ff @(posedge clk_ref) begin
    if (rst) begin
      t_cnt       <= '0;
      armed       <= 1'b0;
      susp_active <= 1'b0;
    end else if (wake) begin
      t_cnt       <= '0;
      armed       <= 1'b0;
      susp_active <= 1'b0;
    end else if (suspend_req && !armed && !susp_active) begin
      t_cnt <= '0;
      armed <= 1'b1;
    end else if (armed) begin
      if (t_cnt == LAST) begin
        armed       <= 1'b0;
        susp_active <= 1'b1;
      end else begin
        t_cnt <= t_cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_ref) begin
    if (rst) core_clk_en <= 1'b1;
    else     core_clk_en <= wake | clk_keep | ~susp_active;
  end
endmodule

// File: rtl/clkout_switch.sv
`timescale 1ns/1ps
module clkout_switch (
  input  logic clk_ref,
  input  logic clk_slow,
  input  logic rst,
  input  logic fast_clk,
  input  logic div_hi,
  input  logic susp_active,
  input  logic slow_off,
  output logic clk_out,
  output logic fast_en,
  output logic slow_en
);
  logic fast_want, slow_want;
  logic grant, s1, s2, b1, busy;

  assign fast_want = ~susp_active;
  assign slow_want = susp_active & ~slow_off;

  // Four-phase request to the slow domain; held until acknowledged
  always_ff @(posedge clk_ref) begin
    if (rst) begin
      grant <= 1'b0;
      b1    <= 1'b0;
      busy  <= 1'b0;
    end else begin
      b1   <= slow_en;
      busy <= b1;
      if (slow_want && !fast_en && !busy) grant <= 1'b1;
      else if (!slow_want && busy)        grant <= 1'b0;
    end
  end

  // Fast gate moves only when the reference is low and the divider is low
  always_ff @(negedge clk_ref) begin
    if (rst) begin
      fast_en <= 1'b1;
    end else if (!div_hi) begin
      if (fast_want && !grant && !busy) fast_en <= 1'b1;
      else if (!fast_want)              fast_en <= 1'b0;
    end
  end

  always_ff @(posedge clk_slow) begin
    if (rst) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
    end else begin
      s1 <= grant;
      s2 <= s1;
    end
  end

  always_ff @(negedge clk_slow) begin
    if (rst) slow_en <= 1'b0;
    else     slow_en <= s2;
  end

  assign clk_out = (fast_clk & fast_en) | (clk_slow & slow_en);
endmodule

// File: rtl/clkout_gen.sv
`timescale 1ns/1ps
module clkout_gen
  import clkout_pkg::*;
#(
  parameter int DELAY = 96000
) (
  input  logic             clk_ref,
  input  logic             clk_slow,
  input  logic             rst,
  input  logic [DIV_W-1:0] div_n,
  input  logic             suspend_req,
  input  logic             wake,
  input  logic             slow_off,
  input  logic             clk_keep,
  output logic             clk_out,
  output logic             core_clk_en
);
  logic             fast_clk, div_hi, susp_active, fast_en, slow_en;
  logic [DIV_W-1:0] cnt_w, n_cur_w;

  clkout_div #(.W(DIV_W)) u_div (
    .clk_ref(clk_ref), .rst(rst), .div_n(div_n),
    .fast_clk(fast_clk), .div_hi(div_hi), .cnt_o(cnt_w), .n_cur_o(n_cur_w)
  );

  clkout_susp #(.DELAY(DELAY)) u_susp (
    .clk_ref(clk_ref), .rst(rst), .suspend_req(suspend_req), .wake(wake),
    .clk_keep(clk_keep), .susp_active(susp_active), .core_clk_en(core_clk_en)
  );

  clkout_switch u_sw (
    .clk_ref(clk_ref), .clk_slow(clk_slow), .rst(rst), .fast_clk(fast_clk),
    .div_hi(div_hi), .susp_active(susp_active), .slow_off(slow_off),
    .clk_out(clk_out), .fast_en(fast_en), .slow_en(slow_en)
  );
endmodule

// File: rtl/clkout_gen_chk.sv
`timescale 1ns/1ps
module clkout_gen_chk
  import clkout_pkg::*;
(
  input logic             clk_ref,
  input logic             rst,
  input logic             fast_en,
  input logic             slow_en,
  input logic             div_hi,
  input logic [DIV_W-1:0] cnt_w,
  input logic [DIV_W-1:0] n_cur_w,
  input logic             clk_keep,
  input logic             wake,
  input logic             core_clk_en
);
  assert_break_before_make_R5: assert property (@(posedge clk_ref) disable iff (rst)
    !(fast_en && slow_en));

  assert_gate_when_low_R6: assert property (@(posedge clk_ref) disable iff (rst)
    $changed(fast_en) |-> !div_hi);

  assert_reload_at_end_R3: assert property (@(posedge clk_ref) disable iff (rst)
    $changed(n_cur_w) |-> $past(cnt_w == n_cur_w));

  assert_keep_enable_R10: assert property (@(posedge clk_ref) disable iff (rst)
    clk_keep |=> core_clk_en);

  assert_wake_enable_R11: assert property (@(posedge clk_ref) disable iff (rst)
    wake |=> core_clk_en);
endmodule

bind clkout_gen clkout_gen_chk u_chk (
  .clk_ref(clk_ref), .rst(rst), .fast_en(fast_en), .slow_en(slow_en),
  .div_hi(div_hi), .cnt_w(cnt_w), .n_cur_w(n_cur_w), .clk_keep(clk_keep),
  .wake(wake), .core_clk_en(core_clk_en)
);

// File: tb/clkout_gen_bench.sv
`timescale 1ns/1ps
module clkout_gen_bench;
  localparam int TREF  = 20;
  localparam int TSLOW = 70;
  localparam int DLY   = 40;

  logic       clk_ref = 0, clk_slow = 0, rst = 1;
  logic [3:0] div_n = 4'd3;
  logic       suspend_req = 0, wake = 0, slow_off = 0, clk_keep = 0;
  logic       clk_out, core_clk_en;

  int n_chk = 0, n_bad = 0;
  time last_rise = 0, last_fall = 0, min_hi = 0, min_lo = 0;
  bit  mon = 0;
  int  rises = 0;

  clkout_gen #(.DELAY(DLY)) u_clkout_gen (
    .clk_ref(clk_ref), .clk_slow(clk_slow), .rst(rst), .div_n(div_n),
    .suspend_req(suspend_req), .wake(wake), .slow_off(slow_off),
    .clk_keep(clk_keep), .clk_out(clk_out), .core_clk_en(core_clk_en)
  );

  always #(TREF/2)  clk_ref  = ~clk_ref;
  always #(TSLOW/2) clk_slow = ~clk_slow;

  always @(posedge clk_out) begin
    rises++;
    if (mon && ($time - last_fall) < min_lo) min_lo = $time - last_fall;
    last_rise = $time;
  end
  always @(negedge clk_out) begin
    if (mon && ($time - last_rise) < min_hi) min_hi = $time - last_rise;
    last_fall = $time;
  end

  task automatic check(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic measure(input string tag, input int per, input int hi);
    time t0, t1, t2;
    @(posedge clk_out); t0 = $time;
    @(negedge clk_out); t1 = $time;
    @(posedge clk_out); t2 = $time;
    check({tag, " period"}, t2 - t0, per);
    check({tag, " high"}, t1 - t0, hi);
  endtask

  task automatic t_reset();
    @(negedge clk_ref);
    check("R1 clk_out in reset", clk_out, 0);
    check("R1 core_clk_en in reset", core_clk_en, 1);
    rst = 0;
    @(posedge clk_ref); #2;
    check("R1 core_clk_en after reset", core_clk_en, 1);
  endtask

  task automatic t_ratio(input int n);
    @(negedge clk_ref); div_n = 4'(n);
    repeat (40) @(negedge clk_ref);
    if (n == 0) measure("R4 pass-through", TREF, TREF/2);
    else        measure($sformatf("R2 N=%0d", n), (n+1)*TREF, ((n+1)/2)*TREF);
  endtask

  task automatic t_runt();
    int seq[6] = '{5, 0, 1, 15, 2, 6};
    min_hi = 1000000; min_lo = 1000000; mon = 1;
    foreach (seq[i]) begin
      repeat (3 + 5*i) @(negedge clk_ref);
      div_n = 4'(seq[i]);
    end
    repeat (60) @(negedge clk_ref);
    mon = 0;
    check("R3 min high >= half ref", (min_hi >= TREF/2), 1);
    check("R3 min low >= half ref", (min_lo >= TREF/2), 1);
    measure("R3 last value applied", 7*TREF, 3*TREF);
  endtask

  task automatic do_suspend();
    @(negedge clk_ref); suspend_req = 1;
    @(posedge clk_ref);
    @(negedge clk_ref); suspend_req = 0;
  endtask

  task automatic do_wake(input int n);
    @(negedge clk_ref); wake = 1;
    @(posedge clk_ref); #2;
    @(negedge clk_ref); wake = 0;
    @(posedge clk_ref); #2;
    check("R11 core_clk_en after wake", core_clk_en, 1);
    repeat (80) @(negedge clk_ref);
    measure("R11 divided clock back", (n+1)*TREF, ((n+1)/2)*TREF);
  endtask

  task automatic t_slow();
    slow_off = 0; clk_keep = 0; div_n = 4'd3;
    @(negedge clk_ref); suspend_req = 1;
    @(posedge clk_ref);
    @(negedge clk_ref); suspend_req = 0;
    repeat (DLY - 1) @(posedge clk_ref);
    @(posedge clk_ref); #2;
    check("R7 core_clk_en before drop", core_clk_en, 1);
    @(posedge clk_ref); #2;
    check("R7 core_clk_en dropped", core_clk_en, 0);
    repeat (60) @(negedge clk_ref);
    measure("R8 slow clock on output", TSLOW, TSLOW/2);
    do_wake(3);
  endtask

  task automatic t_quiet();
    int r0;
    slow_off = 1; clk_keep = 0; div_n = 4'd2;
    do_suspend();
    repeat (DLY + 20) @(negedge clk_ref);
    r0 = rises;
    repeat (100) @(negedge clk_ref);
    check("R9 no edges while quiet", rises - r0, 0);
    check("R9 clk_out low", clk_out, 0);
    check("R7 core_clk_en low in quiet suspend", core_clk_en, 0);
    do_wake(2);
    slow_off = 0;
  endtask

  task automatic t_keep();
    clk_keep = 1; slow_off = 0; div_n = 4'd1;
    do_suspend();
    repeat (DLY + 5) @(negedge clk_ref);
    check("R10 core_clk_en held", core_clk_en, 1);
    repeat (60) @(negedge clk_ref);
    check("R10 core_clk_en still held", core_clk_en, 1);
    measure("R8 slow clock with keep", TSLOW, TSLOW/2);
    do_wake(1);
    clk_keep = 0;
  endtask

  initial begin
    #(400_000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (10) @(negedge clk_ref);
    t_reset();
    t_ratio(3);
    t_ratio(7);
    t_ratio(4);
    t_ratio(0);
    t_ratio(15);
    t_ratio(1);
    t_runt();
    t_slow();
    t_quiet();
    t_keep();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule